// File: doc/BRIEF.md
# Serial Sandwich Pattern Detector

This block watches a serial bit stream, one bit per accepted clock cycle, and flags the moment a "sandwich" closes: the latest bit equals the bit two places earlier while the bit between them differs (the windows 010 and 101). A run of three zeros is also reported, but it ends the history. Once the third zero is seen, the machine returns to its start state, and none of the earlier bits take part in a later window. Three ones never match. Until three bits have been taken since start, the output stays low.

Bits are accepted only when `in_valid` is high. Cycles with `in_valid` low leave the state unchanged and hold the output low. The output is a Mealy decode of the current state and the current input bit, so it reports on the same cycle in which the closing bit is presented. A synchronous reset puts the machine into the same start state that a triple-zero match returns to.

The machine has seven states, and none of them keeps more than two bits of history. `ST_IDLE` means no bits have been seen. `ST_H0` and `ST_H1` hold one bit. `ST_P00`, `ST_P01`, `ST_P10` and `ST_P11` each hold the last two bits, with the older bit written first. On an accepted bit b, the transitions are:
- IDLE→H(b)
- H0→P0b
- H1→P1b
- P00 with 0 goes to IDLE and reports a match
- P00 with 1 goes to P01
- P01 goes to P1b, and reports a match on 0
- P10 goes to P0b, and reports a match on 1
- P11 goes to P1b, and never reports a match

Top module: `sandwich_detector`

## Requirements
- R1: After reset, and after any restart, the first two accepted bits give `match_out` = 0.
- R2: An accepted 0 whose two preceding accepted bits were 0 then 1 (window 010) gives `match_out` = 1 in that cycle.
- R3: An accepted 1 whose two preceding accepted bits were 1 then 0 (window 101) gives `match_out` = 1 in that cycle.
- R4: The windows 111, 110, 011, 001 and 100 give `match_out` = 0.
- R5: A third consecutive accepted 0 gives `match_out` = 1 and returns the machine to the start state. The next two accepted bits therefore give 0.
- R6: When `in_valid` = 0, `match_out` = 0, and the cycle has no effect on later outputs.
- R7: Sandwiches that overlap are all reported. The input 01010 gives 00111.
- R8: A synchronous reset with `rst` = 1 discards the history. The machine behaves as at start.
- R9: The accepted input 001010001010, starting from reset, gives the output sequence 000111010011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input bit is accepted this cycle |
| in_bit | input | 1 | Serial data bit |
| match_out | output | 1 | Pattern detected on the current accepted bit (Mealy) |

## Verification
The bench first targets the clearing effect of a triple zero. In the stream 1,0,0,0,1,0, the final 0 would close a 010 window if the history were kept; a design that did not clear the history would raise a false match there. It also checks that a zero run after the clear needs a full three fresh zeros. Invalid cycles are placed between the bits of a sandwich, with `in_bit` toggling while `in_valid` is low. A design that consumed or shifted on those cycles would lose or create a match. Long runs of ones, overlapping sandwiches and a reset placed just before a closing bit are also covered. Each of these catches a design that matches 111, reports only the first of overlapping patterns, or keeps history across reset.

// File: rtl/sandwich_pkg.sv
package sandwich_pkg;

    // History held by the detector: number of bits seen and their values.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // nothing seen since start
        ST_H0   = 3'd1,  // one bit seen, it was 0
        ST_H1   = 3'd2,  // one bit seen, it was 1
        ST_P00  = 3'd3,  // last two bits 0,0 (older first)
        ST_P01  = 3'd4,  // last two bits 0,1
        ST_P10  = 3'd5,  // last two bits 1,0
        ST_P11  = 3'd6   // last two bits 1,1
    } det_state_t;

endpackage

// File: rtl/sandwich_next.sv
module sandwich_next
    import sandwich_pkg::*;
(
    input  det_state_t cur,
    input  logic       take,
    input  logic       bit_in,
    output det_state_t nxt
);

    det_state_t shifted;

    always_comb begin
        unique case (cur)
            ST_IDLE: shifted = bit_in ? ST_H1  : ST_H0;
            ST_H0:   shifted = bit_in ? ST_P01 : ST_P00;
            ST_H1:   shifted = bit_in ? ST_P11 : ST_P10;
            ST_P00:  shifted = bit_in ? ST_P01 : ST_IDLE;  // third zero restarts
            ST_P01:  shifted = bit_in ? ST_P11 : ST_P10;
            ST_P10:  shifted = bit_in ? ST_P01 : ST_P00;
            ST_P11:  shifted = bit_in ? ST_P11 : ST_P10;
            default: shifted = ST_IDLE;
        endcase
    end

    assign nxt = take ? shifted : cur;

endmodule

// File: rtl/sandwich_match.sv
module sandwich_match
    import sandwich_pkg::*;
(
    input  det_state_t cur,
    input  logic       take,
    input  logic       bit_in,
    output logic       hit
);

    logic closes;

    always_comb begin
        unique case (cur)
            ST_P00:  closes = !bit_in;  // 000
            ST_P01:  closes = !bit_in;  // 010
            ST_P10:  closes = bit_in;   // 101
            ST_IDLE, ST_H0, ST_H1, ST_P11: closes = 1'b0;
            default: closes = 1'b0;
        endcase
    end

    assign hit = take & closes;

endmodule

// File: rtl/sandwich_detector.sv
module sandwich_detector
    import sandwich_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic match_out
);

    det_state_t state;
    det_state_t state_nxt;

    sandwich_next u_next (
        .cur    (state),
        .take   (in_valid),
        .bit_in (in_bit),
        .nxt    (state_nxt)
    );

    sandwich_match u_match (
        .cur    (state),
        .take   (in_valid),
        .bit_in (in_bit),
        .hit    (match_out)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // R6: idle cycles give no output and keep the history
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !match_out);
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(state));

    // R1: fewer than two bits of history never reports
    a_r1_short_history: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_H0 || state == ST_H1) |-> !match_out);

    // R5: third zero reports and restarts
    a_r5_triple_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state == ST_P00 && !in_bit) |-> match_out);
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state == ST_P00 && !in_bit) |=> state == ST_IDLE);

    // R4: 111 is not a sandwich
    a_r4_no_triple_one: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state == ST_P11 && in_bit) |-> !match_out);

    // R2 / R3: both sandwich windows report
    a_r2_zero_sandwich: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state == ST_P01 && !in_bit) |-> match_out);
    a_r3_one_sandwich: assert property (@(posedge clk) disable iff (rst)
        (in_valid && state == ST_P10 && in_bit) |-> match_out);

endmodule

// File: tb/sandwich_detector_test.sv
`timescale 1ns/1ps
module sandwich_detector_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic match_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    sandwich_detector uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .match_out (match_out)
    );

    task automatic send(input logic b, input logic exp, input string tag);
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b1;
        in_bit   = b;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic b);
        @(negedge clk);
        in_valid = 1'b0;
        in_bit   = b;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_seq(input logic [15:0] bits, input logic [15:0] exps,
                            input int n, input string tag);
        for (int i = n - 1; i >= 0; i--) send(bits[i], exps[i], tag);
    endtask

    // Monitor: sample between the driving negedge and the next posedge
    always begin
        @(negedge clk);
        #4;
        if (!rst) begin
            if (in_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard: unexpected accepted bit, match_out=%0b expected none", match_out);
                end else begin
                    logic e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (match_out !== e) begin
                        errors++;
                        $display("FAIL %s: match_out=%0b expected %0b", t, match_out, e);
                    end
                end
            end else begin
                checks++;
                if (match_out !== 1'b0) begin
                    errors++;
                    $display("FAIL R6: match_out=%0b expected 0 while idle", match_out);
                end
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        // R1: reset state, output low
        #1;
        checks++;
        if (match_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: match_out=%0b expected 0 after reset", match_out);
        end

        // R9 reference sequence (first two bits also cover R1)
        send_seq(16'b001010001010, 16'b000111010011, 12, "R9");

        // R4 runs of ones, then R3 closes 101
        do_reset();
        send_seq(16'b1111, 16'b0000, 4, "R4");
        send(1'b0, 1'b0, "R4");   // 110
        send(1'b1, 1'b1, "R3");   // 101
        send(1'b1, 1'b0, "R4");   // 011
        send(1'b0, 1'b0, "R4");   // 110

        // R7 overlapping sandwiches, R2
        do_reset();
        send_seq(16'b01010, 16'b00111, 5, "R7");
        send(1'b0, 1'b0, "R4");   // 100
        send(1'b1, 1'b0, "R4");   // 001

        // R6 idle cycles inside a sandwich
        do_reset();
        send(1'b0, 1'b0, "R6");
        idle(1'b1); idle(1'b0); idle(1'b1);
        send(1'b1, 1'b0, "R6");
        idle(1'b0); idle(1'b1);
        send(1'b0, 1'b1, "R6");   // 010 across idles

        // R5 triple zero clears history
        do_reset();
        send_seq(16'b1000, 16'b0001, 4, "R5");
        send(1'b1, 1'b0, "R5");   // fresh first bit
        send(1'b0, 1'b0, "R5");   // would be 010 without clear
        send(1'b1, 1'b1, "R3");   // 101
        do_reset();
        send_seq(16'b000000, 16'b001001, 6, "R5");

        // R8 reset mid-stream
        do_reset();
        send(1'b0, 1'b0, "R8");
        send(1'b1, 1'b0, "R8");
        do_reset();
        send(1'b0, 1'b0, "R8");   // would close 010 without reset
        send(1'b1, 1'b0, "R8");
        send(1'b0, 1'b1, "R2");

        idle(1'b0); idle(1'b0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expected items left, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule